// File: doc/BRIEF.md
# LCD Frame Clock Prescaler

This block turns a slow LCD source clock into the phase-rate enable that steps a multiplexed segment display. The division uses two 4-bit settings. The first is a power-of-two prescale. The second is a linear offset added to a base count of sixteen. One phase lasts `2^ps * (16 + div)` source cycles. The block emits a single-cycle `phaseTick` at that rate and keeps a running common-phase index. It also raises `frameStart` once per full set of four phases.

Software writes the settings in the bus clock domain. They cross into the LCD clock domain through a toggle request and acknowledge, each passed through a two-flop synchronizer. The LCD side applies a new pair only at a frame boundary, so no phase is ever cut short. `syncDone` falls when a write is accepted. It rises again only after the LCD domain has applied the values and the acknowledge has returned. Software therefore polls `syncDone` before relying on a new rate. A write that lands while an earlier one is still in flight is held and sent again once that request is acknowledged. The last written pair always takes effect.

Top module: `lcd_frame_prescaler`

## Requirements
- R1: While the LCD reset is asserted, `phaseTick` and `frameStart` stay low. After reset, `phaseIdx` is 0, `syncDone` is 1, and each phase lasts 16 LCD clock cycles (prescale 0, offset 0).
- R2: With applied settings `ps` and `div`, consecutive `phaseTick` pulses are exactly `2^ps * (16 + div)` LCD clock cycles apart.
- R3: `phaseTick` is high for exactly one LCD clock cycle per phase.
- R4: Each `phaseTick` moves `phaseIdx` to the next value modulo 4, and `phaseIdx` holds between ticks. `frameStart` is high exactly in the cycle whose `phaseTick` ends phase 3.
- R5: A bus cycle with `wrEn` high makes `syncDone` read 0 from the next rising `busClk` edge.
- R6: A new setting never changes the length of phases 1 to 3. The first phase that runs at a changed length is always phase 0.
- R7: `syncDone` returns to 1 on its own after a write. Once it reads 1, every complete phase that follows has the newly written length.
- R8: `wrPs` = 4 together with `wrDiv` = 1 gives phases of 272 LCD cycles (a prescale of 16 followed by a divide by 17).
- R9: When a second write arrives while an earlier one is still pending, `syncDone` stays 0 until the second pair is in effect, and the second pair sets the final phase length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus-side clock for setting writes |
| busRstN | input | 1 | Active-low asynchronous reset, bus domain |
| wrEn | input | 1 | One-cycle write strobe for the divider settings |
| wrPs | input | 4 | Power-of-two prescale exponent to write |
| wrDiv | input | 4 | Offset added to 16 for the linear divider |
| syncDone | output | 1 | High when the last written settings are in effect |
| lcdClk | input | 1 | Low-frequency LCD source clock |
| lcdRstN | input | 1 | Active-low asynchronous reset, LCD domain |
| phaseTick | output | 1 | Single-cycle enable at the phase rate |
| frameStart | output | 1 | Pulse with the tick that wraps the phase index to 0 |
| phaseIdx | output | 2 | Index of the common phase now running |

## Verification
Two actions can land in the same LCD cycle: the load of a pending setting and the frame-start tick. This is by design, because loads are allowed only there. To provoke it, the bench writes settings at arbitrary points in a frame. A free-running monitor then checks that, whenever the phase length changes, the phase that just ended with the new length is phase 0. A second collision is a bus write that arrives while an earlier request is still pending. The bench issues two writes a few bus cycles apart. It then checks that `syncDone` stays low and that the phase length settles on the second pair.

// File: rtl/lcdpre_pkg.sv
package lcdpre_pkg;

  // width of each divider setting field
  localparam int FLD_W = 4;

  // control -> datapath strobes, LCD clock domain
  typedef struct packed {
    logic             load;   // apply newPs/newDiv at this frame boundary
    logic [FLD_W-1:0] newPs;
    logic [FLD_W-1:0] newDiv;
  } lcdStrobe_t;

endpackage

// File: rtl/lcdpre_sync.sv
module lcdpre_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stage;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[0] <= 1'b0;
          else       stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[i] <= 1'b0;
          else       stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/lcdpre_ctrl.sv
module lcdpre_ctrl
  import lcdpre_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  // bus domain
  input  logic             busClk,
  input  logic             busRstN,
  input  logic             wrEn,
  input  logic [FLD_W-1:0] wrPs,
  input  logic [FLD_W-1:0] wrDiv,
  output logic             syncDone,
  // LCD domain
  input  logic             lcdClk,
  input  logic             lcdRstN,
  input  logic             frameEnd,
  output lcdStrobe_t       strobe
);

  // ---------------- bus side ----------------
  logic             reqTgl;
  logic             ackSeen;
  logic             again;       // a write arrived while a request was in flight
  logic [FLD_W-1:0] holdPs, holdDiv;       // values carried by the live request
  logic [FLD_W-1:0] shadowPs, shadowDiv;   // newest write waiting to be sent
  logic             syncDoneQ;
  logic             busPending;

  assign busPending = reqTgl ^ ackSeen;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      reqTgl    <= 1'b0;
      again     <= 1'b0;
      holdPs    <= '0;
      holdDiv   <= '0;
      shadowPs  <= '0;
      shadowDiv <= '0;
      syncDoneQ <= 1'b1;
    end else begin
      if (wrEn && !busPending) begin
        // channel idle: launch directly
        holdPs  <= wrPs;
        holdDiv <= wrDiv;
        reqTgl  <= ~reqTgl;
        again   <= 1'b0;
      end else if (wrEn) begin
        // hold data must stay stable while pending: park the write
        shadowPs  <= wrPs;
        shadowDiv <= wrDiv;
        again     <= 1'b1;
      end else if (again && !busPending) begin
        // previous request acknowledged: replay the parked write
        holdPs  <= shadowPs;
        holdDiv <= shadowDiv;
        reqTgl  <= ~reqTgl;
        again   <= 1'b0;
      end
      syncDoneQ <= !wrEn && !busPending && !again;
    end
  end

  assign syncDone = syncDoneQ;

  // ---------------- LCD side ----------------
  logic reqSeen;
  logic ackTgl;
  logic lcdPending;
  logic loadNow;

  lcdpre_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk  (lcdClk),
    .rstN (lcdRstN),
    .d    (reqTgl),
    .q    (reqSeen)
  );

  assign lcdPending = reqSeen ^ ackTgl;
  assign loadNow    = lcdPending && frameEnd;

  always_ff @(posedge lcdClk or negedge lcdRstN) begin
    if (!lcdRstN) ackTgl <= 1'b0;
    else if (loadNow) ackTgl <= reqSeen;
  end

  always_comb begin
    strobe.load   = loadNow;
    strobe.newPs  = holdPs;    // stable while the request is pending
    strobe.newDiv = holdDiv;
  end

  lcdpre_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk  (busClk),
    .rstN (busRstN),
    .d    (ackTgl),
    .q    (ackSeen)
  );

endmodule

// File: rtl/lcdpre_datapath.sv
module lcdpre_datapath
  import lcdpre_pkg::*;
#(
  parameter int BASE_COUNT = 16,
  parameter int PHASES     = 4
) (
  input  logic                       lcdClk,
  input  logic                       lcdRstN,
  input  lcdStrobe_t                 strobe,
  output logic                       phaseTick,
  output logic                       frameStart,
  output logic [$clog2(PHASES)-1:0]  phaseIdx
);

  localparam int PRE_W = (1 << FLD_W) - 1;                       // 2^15 max prescale
  localparam int DC_W  = $clog2(BASE_COUNT + (1 << FLD_W));      // holds BASE+15-1
  localparam int PH_W  = $clog2(PHASES);

  logic [FLD_W-1:0] actPs, actDiv;
  logic [PRE_W-1:0] preCnt, preMask;
  logic [DC_W-1:0]  divCnt, divLimit;
  logic [PH_W-1:0]  phaseQ;
  logic             preTick;

  // applied settings change only at a frame boundary
  always_ff @(posedge lcdClk or negedge lcdRstN) begin
    if (!lcdRstN) begin
      actPs  <= '0;
      actDiv <= '0;
    end else if (strobe.load) begin
      actPs  <= strobe.newPs;
      actDiv <= strobe.newDiv;
    end
  end

  // for the largest exponent the shift wraps to zero and the subtract
  // yields the all-ones mask, which is the intended terminal count
  always_comb begin
    preMask  = (PRE_W'(1) << actPs) - PRE_W'(1);
    divLimit = DC_W'(BASE_COUNT - 1) + DC_W'(actDiv);
  end

  assign preTick   = (preCnt == preMask);
  assign phaseTick = preTick && (divCnt == divLimit);
  assign frameStart = phaseTick && (phaseQ == PH_W'(PHASES - 1));

  // power-of-two stage
  always_ff @(posedge lcdClk or negedge lcdRstN) begin
    if (!lcdRstN)     preCnt <= '0;
    else if (preTick) preCnt <= '0;
    else              preCnt <= preCnt + PRE_W'(1);
  end

  // linear stage, advances on prescale enables
  always_ff @(posedge lcdClk or negedge lcdRstN) begin
    if (!lcdRstN)       divCnt <= '0;
    else if (phaseTick) divCnt <= '0;
    else if (preTick)   divCnt <= divCnt + DC_W'(1);
  end

  // common-phase index
  always_ff @(posedge lcdClk or negedge lcdRstN) begin
    if (!lcdRstN)        phaseQ <= '0;
    else if (frameStart) phaseQ <= '0;
    else if (phaseTick)  phaseQ <= phaseQ + PH_W'(1);
  end

  assign phaseIdx = phaseQ;

endmodule

// File: rtl/lcd_frame_prescaler.sv
module lcd_frame_prescaler
  import lcdpre_pkg::*;
#(
  parameter int BASE_COUNT  = 16,
  parameter int PHASES      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      busClk,
  input  logic                      busRstN,
  input  logic                      wrEn,
  input  logic [FLD_W-1:0]          wrPs,
  input  logic [FLD_W-1:0]          wrDiv,
  output logic                      syncDone,
  input  logic                      lcdClk,
  input  logic                      lcdRstN,
  output logic                      phaseTick,
  output logic                      frameStart,
  output logic [$clog2(PHASES)-1:0] phaseIdx
);

  lcdStrobe_t strobe;
  logic       frameEnd;

  lcdpre_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .busClk   (busClk),
    .busRstN  (busRstN),
    .wrEn     (wrEn),
    .wrPs     (wrPs),
    .wrDiv    (wrDiv),
    .syncDone (syncDone),
    .lcdClk   (lcdClk),
    .lcdRstN  (lcdRstN),
    .frameEnd (frameEnd),
    .strobe   (strobe)
  );

  lcdpre_datapath #(.BASE_COUNT(BASE_COUNT), .PHASES(PHASES)) u_dp (
    .lcdClk     (lcdClk),
    .lcdRstN    (lcdRstN),
    .strobe     (strobe),
    .phaseTick  (phaseTick),
    .frameStart (frameStart),
    .phaseIdx   (phaseIdx)
  );

  assign frameEnd = frameStart;

endmodule

// File: rtl/lcdpre_checker.sv
module lcdpre_checker #(
  parameter int PHASES = 4
) (
  input logic                      busClk,
  input logic                      busRstN,
  input logic                      wrEn,
  input logic                      syncDone,
  input logic                      lcdClk,
  input logic                      lcdRstN,
  input logic                      phaseTick,
  input logic                      frameStart,
  input logic [$clog2(PHASES)-1:0] phaseIdx
);

  localparam int PH_W = $clog2(PHASES);

  // R1: no strobes while held in reset
  always @(negedge lcdClk) begin
    if (lcdRstN === 1'b0) begin
      p_quiet_in_reset_r1: assert (!phaseTick && !frameStart);
    end
  end

  // R3
  p_tick_single_r3: assert property (@(posedge lcdClk) disable iff (!lcdRstN)
    phaseTick |=> !phaseTick);

  // R4
  p_frame_on_last_r4: assert property (@(posedge lcdClk) disable iff (!lcdRstN)
    frameStart |-> (phaseTick && phaseIdx == PH_W'(PHASES - 1)));

  p_idx_step_r4: assert property (@(posedge lcdClk) disable iff (!lcdRstN)
    phaseTick |=> phaseIdx == (($past(phaseIdx) == PH_W'(PHASES - 1)) ?
                               PH_W'(0) : $past(phaseIdx) + PH_W'(1)));

  p_idx_hold_r4: assert property (@(posedge lcdClk) disable iff (!lcdRstN)
    !phaseTick |=> $stable(phaseIdx));

  // R5
  p_write_clears_r5: assert property (@(posedge busClk) disable iff (!busRstN)
    wrEn |=> !syncDone);

  // R9: completion never reported in the cycle after a write
  p_no_early_done_r9: assert property (@(posedge busClk) disable iff (!busRstN)
    $rose(syncDone) |-> !$past(wrEn));

endmodule

bind lcd_frame_prescaler lcdpre_checker #(.PHASES(PHASES)) u_checker (
  .busClk     (busClk),
  .busRstN    (busRstN),
  .wrEn       (wrEn),
  .syncDone   (syncDone),
  .lcdClk     (lcdClk),
  .lcdRstN    (lcdRstN),
  .phaseTick  (phaseTick),
  .frameStart (frameStart),
  .phaseIdx   (phaseIdx)
);

// File: tb/tb_lcd_frame_prescaler.sv
`timescale 1ns/1ps
module tb_lcd_frame_prescaler;

  logic       busClk = 1'b0;
  logic       lcdClk = 1'b0;
  logic       busRstN = 1'b0;
  logic       lcdRstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrPs = '0;
  logic [3:0] wrDiv = '0;
  logic       syncDone;
  logic       phaseTick;
  logic       frameStart;
  logic [1:0] phaseIdx;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 busClk = ~busClk;   // 50 MHz
  always #7  lcdClk = ~lcdClk;

  lcd_frame_prescaler dut (
    .busClk(busClk), .busRstN(busRstN), .wrEn(wrEn), .wrPs(wrPs), .wrDiv(wrDiv),
    .syncDone(syncDone), .lcdClk(lcdClk), .lcdRstN(lcdRstN),
    .phaseTick(phaseTick), .frameStart(frameStart), .phaseIdx(phaseIdx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- phase monitor (samples at falling lcdClk) ----------------
  int  sinceTick = 0;
  int  lastLen   = 0;
  int  prevLen   = 0;
  int  tickCount = 0;
  int  expIdx    = 0;
  bit  prevTick  = 1'b0;

  always @(negedge lcdClk) begin
    if (lcdRstN) begin
      sinceTick++;
      if (phaseTick && prevTick) check(1'b0, "R3 tick wider than one cycle", 2, 1);
      if (frameStart && !phaseTick) check(1'b0, "R4 frameStart without tick", 0, 1);
      if (phaseTick) begin
        check(int'(phaseIdx) == expIdx, "R4 phase index sequence", phaseIdx, expIdx);
        check(frameStart == (expIdx == 3), "R4 frameStart on last phase", frameStart, expIdx == 3);
        if (tickCount > 0) begin
          prevLen = lastLen;
          lastLen = sinceTick;
          if (tickCount > 1 && lastLen != prevLen)
            check(phaseIdx == 2'd0, "R6 first changed phase is phase 0", phaseIdx, 0);
        end
        expIdx    = (expIdx + 1) % 4;
        sinceTick = 0;
        tickCount++;
      end
      prevTick = phaseTick;
    end
  end

  task automatic waitTicks(input int n);
    int target;
    target = tickCount + n;
    while (tickCount < target) @(negedge lcdClk);
  endtask

  task automatic busWrite(input logic [3:0] ps, input logic [3:0] dv);
    @(negedge busClk);
    wrEn = 1'b1; wrPs = ps; wrDiv = dv;
    @(negedge busClk);
    wrEn = 1'b0;
    check(syncDone == 1'b0, "R5 syncDone low after write", syncDone, 0);
  endtask

  task automatic waitSync(input string tag);
    int n = 0;
    while (!syncDone && n < 20000) begin
      @(negedge busClk);
      n++;
    end
    check(syncDone == 1'b1, tag, syncDone, 1);
  endtask

  // {ps, div, expected phase length}
  localparam logic [23:0] VEC [8] = '{
    {4'd1, 4'd0,  16'd32},
    {4'd0, 4'd15, 16'd31},
    {4'd2, 4'd3,  16'd76},
    {4'd4, 4'd1,  16'd272},
    {4'd0, 4'd1,  16'd17},
    {4'd3, 4'd7,  16'd184},
    {4'd2, 4'd15, 16'd124},
    {4'd0, 4'd0,  16'd16}
  };

  initial begin
    // R1 reset behaviour
    repeat (4) @(negedge lcdClk) begin
      check(!phaseTick && !frameStart, "R1 strobes quiet in reset", phaseTick, 0);
    end
    @(negedge busClk);
    busRstN = 1'b1;
    lcdRstN = 1'b1;
    @(negedge busClk);
    check(syncDone == 1'b1, "R1 syncDone after reset", syncDone, 1);
    check(phaseIdx == 2'd0, "R1 phaseIdx after reset", phaseIdx, 0);
    waitTicks(3);
    check(lastLen == 16, "R1 default phase length", lastLen, 16);

    // table walk: R2, R7, R8
    for (int i = 0; i < 8; i++) begin
      logic [3:0]  ps;
      logic [3:0]  dv;
      logic [15:0] expLen;
      {ps, dv, expLen} = VEC[i];
      busWrite(ps, dv);
      waitSync("R7 syncDone returns");
      waitTicks(2);
      if (ps == 4'd4 && dv == 4'd1)
        check(lastLen == int'(expLen), "R8 prescale 16 then divide 17", lastLen, expLen);
      else
        check(lastLen == int'(expLen), "R2 R7 phase length after sync", lastLen, expLen);
    end

    // R9: second write while the first is pending
    busWrite(4'd1, 4'd2);
    repeat (2) @(negedge busClk);
    busWrite(4'd0, 4'd5);
    check(syncDone == 1'b0, "R9 still pending after second write", syncDone, 0);
    waitSync("R9 syncDone after replay");
    waitTicks(2);
    check(lastLen == 21, "R9 last write wins", lastLen, 21);

    // R6: write mid-frame, then observe several frames across the switch
    waitTicks(1);
    busWrite(4'd1, 4'd1);
    waitSync("R6 sync after mid-frame write");
    waitTicks(6);
    check(lastLen == 34, "R6 new length in use", lastLen, 34);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule